// File: doc/BRIEF.md
# Chain-Indexed I/O Translation Cache

This block translates DMA addresses. A device presents an I/O virtual address. The block finds a 40-bit physical page number, a 12-bit coherence index and four DMA hint flags for that address. The table is direct mapped with 256 slots. The slot is chosen by an 8-bit chain field cut out of the address. The position of that field is given by a mask input, and the lowest set bit of the mask marks the field's least significant bit. Each slot holds the full virtual page number as its tag, together with the raw 64-bit directory entry.

A 2-bit mode input picks how the block translates:
- In the direct mode, the virtual page passes straight through.
- In the software mode, only entries written by command are used, and a miss faults.
- In the fetch mode, a miss reads the entry from a page directory in memory through a request/response port. The block stalls further lookups until that read returns.

Software maintains the table through a command word. Its low 12 bits hold the operation code and its upper bits hold the page address.

Top module: `iotlb_chain`

## Requirements
- R1: After reset there is no result (res_valid_o low), no memory request, lk_ready_o is high, and every slot is empty, so a software-mode lookup faults.
- R2: The slot index is the 8 address bits starting at the lowest set bit of chain_mask_i. A hit needs the stored virtual page (address bits 31:12) to equal the looked-up page, so two pages sharing an index evict each other.
- R3: In mode 0, a lookup yields a result one cycle later. That result has no fault, res_ppn_o equal to the zero-extended virtual page, and zero hints and coherence index. The table is not changed.
- R4: A command with low 12 bits equal to 35 writes the indexed slot: the tag comes from bits 31:12, word 0 from stage_hi_i and word 1 from stage_lo_i. Code 33 empties the indexed slot whatever its tag. Any other code has no effect.
- R5: A hit decodes the entry as follows. res_ppn_o = {word0[31:28], word0[15:0], word1[31:12]}. res_cidx_o = word0[27:16]. res_hint_o = {prefetch word1[6], update word1[5], lock word1[2], safe word1[1]}.
- R6: An entry whose word1 bit 0 (valid) is 0 never hits.
- R7: In modes 1 and 3, a miss gives a fault result one cycle later: res_fault_o high, with ppn, cidx and hint all zero. No memory request is made.
- R8: In mode 2, a miss raises mem_req_o for exactly one cycle, in the cycle after the lookup, with mem_addr_o = pdir_base_i + page×8. lk_ready_o stays low from then until the response is taken.
- R9: If the fetched entry is valid, the result decodes it in the cycle after mem_rsp_valid_i and the slot is filled. If it is invalid, the result is a fault and the slot is left unchanged.
- R10: A purge or write to the fetch's slot, made in any cycle from the missing lookup through the response cycle, cancels the fill. The fetched result is still returned.
- R11: A lookup in the same cycle as a command sees the table as it was before the command.
- R12: mem_rsp_valid_i while no fetch is waiting produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 direct, 1 software only, 2 fetch on miss, 3 as 1 |
| chain_mask_i | input | 32 | 8-bit mask placing the chain field |
| pdir_base_i | input | 32 | Page directory base byte address |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_word_i | input | 32 | Page address [31:12], operation code [11:0] |
| stage_hi_i | input | 32 | Entry word 0 for a direct write |
| stage_lo_i | input | 32 | Entry word 1 for a direct write |
| lk_valid_i | input | 1 | Lookup request |
| lk_iova_i | input | 32 | Lookup I/O virtual address |
| lk_ready_o | output | 1 | Lookup accepted this cycle when high |
| res_valid_o | output | 1 | Result strobe |
| res_fault_o | output | 1 | Translation fault |
| res_ppn_o | output | 40 | Physical page number |
| res_cidx_o | output | 12 | Coherence index |
| res_hint_o | output | 4 | {prefetch, update, lock, safe} |
| mem_req_o | output | 1 | Directory read request, one cycle |
| mem_addr_o | output | 32 | Directory entry byte address |
| mem_rsp_valid_i | input | 1 | Directory read data valid |
| mem_rsp_data_i | input | 64 | Directory entry, word 0 in [63:32] |

## Verification
Two pairs of events can fall on the same clock edge. A table command can arrive in the same cycle as a lookup. A command can also hit the very slot that a running fetch is about to fill. The bench drives a purge together with a lookup of that slot, and expects the old hit followed by a miss on the next lookup. It also drives a purge to a slot while the directory read for that slot is still pending. There it expects the fetched translation to come back but no later hit. Random traffic mixes these collisions with writes and purges drawn from a small pool of pages, so that hits, evictions and cancellations all occur often.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;
  localparam int PPN_W  = 40;
  localparam int CIDX_W = 12;
  localparam int HINT_W = 4;

  localparam logic [1:0] TM_REAL  = 2'd0;
  localparam logic [1:0] TM_FETCH = 2'd2;

  localparam int OP_PURGE  = 33;
  localparam int OP_DWRITE = 35;

  typedef struct packed {
    logic [PPN_W-1:0]  ppn;
    logic [CIDX_W-1:0] cidx;
    logic [HINT_W-1:0] hint;
  } xlat_t;

  // entry[63:32] = word 0, entry[31:0] = word 1
  function automatic xlat_t pde_decode(input logic [63:0] e);
    xlat_t x;
    x.ppn  = {e[63:60], e[47:32], e[31:12]};
    x.cidx = e[59:48];
    x.hint = {e[6], e[5], e[2], e[1]};
    return x;
  endfunction
endpackage

// File: rtl/iotlb_cidx.sv
module iotlb_cidx #(
  parameter int VA_W  = 32,
  parameter int CID_W = 8
) (
  input  logic [VA_W-1:0]  mask_i,
  input  logic [VA_W-1:0]  addr_i,
  output logic [CID_W-1:0] idx_o
);
  localparam int SH_W = $clog2(VA_W);

  logic [SH_W-1:0] shift;

  // lowest set mask bit marks the field LSB
  always_comb begin
    shift = '0;
    for (int i = VA_W - 1; i >= 0; i--) begin
      if (mask_i[i]) shift = SH_W'(i);
    end
  end

  logic [VA_W-1:0] shifted;
  assign shifted = addr_i >> shift;
  assign idx_o   = shifted[CID_W-1:0];
endmodule

// File: rtl/iotlb_store.sv
module iotlb_store #(
  parameter int CID_W = 8,
  parameter int VPN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CID_W-1:0] rd_idx_i,
  output logic             rd_present_o,
  output logic [VPN_W-1:0] rd_tag_o,
  output logic [63:0]      rd_data_o,
  input  logic             cmd_we_i,
  input  logic             cmd_clr_i,
  input  logic [CID_W-1:0] cmd_idx_i,
  input  logic [VPN_W-1:0] cmd_tag_i,
  input  logic [63:0]      cmd_data_i,
  input  logic             fill_we_i,
  input  logic [CID_W-1:0] fill_idx_i,
  input  logic [VPN_W-1:0] fill_tag_i,
  input  logic [63:0]      fill_data_i
);
  localparam int ENTRIES = 1 << CID_W;

  logic [ENTRIES-1:0] present_q;
  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  logic [63:0]        data_q [ENTRIES];

  assign rd_present_o = present_q[rd_idx_i];
  assign rd_tag_o     = tag_q[rd_idx_i];
  assign rd_data_o    = data_q[rd_idx_i];

  // command port written last: wins on a shared slot
  always_ff @(posedge clk_i) begin
    if (fill_we_i) begin
      tag_q[fill_idx_i]  <= fill_tag_i;
      data_q[fill_idx_i] <= fill_data_i;
    end
    if (cmd_we_i) begin
      tag_q[cmd_idx_i]  <= cmd_tag_i;
      data_q[cmd_idx_i] <= cmd_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      present_q <= '0;
    end else begin
      if (fill_we_i) present_q[fill_idx_i] <= 1'b1;
      if (cmd_we_i)  present_q[cmd_idx_i]  <= 1'b1;
      if (cmd_clr_i) present_q[cmd_idx_i]  <= 1'b0;
    end
  end
endmodule

// File: rtl/iotlb_walk.sv
module iotlb_walk #(
  parameter int VA_W  = 32,
  parameter int VPN_W = 20,
  parameter int CID_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [CID_W-1:0] idx_i,
  input  logic [VA_W-1:0]  base_i,
  input  logic             cmd_act_i,
  input  logic [CID_W-1:0] cmd_idx_i,
  input  logic             rsp_valid_i,
  input  logic [63:0]      rsp_data_i,
  output logic             busy_o,
  output logic             req_o,
  output logic [VA_W-1:0]  addr_o,
  output logic             done_o,
  output logic             fill_o,
  output logic [CID_W-1:0] fill_idx_o,
  output logic [VPN_W-1:0] fill_tag_o
);
  typedef enum logic [1:0] {W_IDLE, W_REQ, W_WAIT} wstate_e;

  wstate_e          state_q;
  logic [VPN_W-1:0] vpn_q;
  logic [CID_W-1:0] idx_q;
  logic [VA_W-1:0]  addr_q;
  logic             cancel_q;
  logic             cmd_same;

  assign cmd_same = cmd_act_i &&
                    (cmd_idx_i == ((state_q == W_IDLE) ? idx_i : idx_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= W_IDLE;
      vpn_q    <= '0;
      idx_q    <= '0;
      addr_q   <= '0;
      cancel_q <= 1'b0;
    end else begin
      unique case (state_q)
        W_IDLE: if (start_i) begin
          state_q  <= W_REQ;
          vpn_q    <= vpn_i;
          idx_q    <= idx_i;
          addr_q   <= base_i + VA_W'({vpn_i, 3'b000});
          cancel_q <= cmd_same;
        end
        W_REQ: begin
          state_q  <= W_WAIT;
          cancel_q <= cancel_q | cmd_same;
        end
        W_WAIT: begin
          cancel_q <= cancel_q | cmd_same;
          if (rsp_valid_i) state_q <= W_IDLE;
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != W_IDLE);
  assign req_o      = (state_q == W_REQ);
  assign addr_o     = addr_q;
  assign done_o     = (state_q == W_WAIT) && rsp_valid_i;
  assign fill_o     = done_o && rsp_data_i[0] && !cancel_q && !cmd_same;
  assign fill_idx_o = idx_q;
  assign fill_tag_o = vpn_q;
endmodule

// File: rtl/iotlb_chain.sv
module iotlb_chain
  import iotlb_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PG_W  = 12,
  parameter int CID_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          mode_i,
  input  logic [VA_W-1:0]     chain_mask_i,
  input  logic [VA_W-1:0]     pdir_base_i,
  input  logic                cmd_valid_i,
  input  logic [VA_W-1:0]     cmd_word_i,
  input  logic [31:0]         stage_hi_i,
  input  logic [31:0]         stage_lo_i,
  input  logic                lk_valid_i,
  input  logic [VA_W-1:0]     lk_iova_i,
  output logic                lk_ready_o,
  output logic                res_valid_o,
  output logic                res_fault_o,
  output logic [PPN_W-1:0]    res_ppn_o,
  output logic [CIDX_W-1:0]   res_cidx_o,
  output logic [HINT_W-1:0]   res_hint_o,
  output logic                mem_req_o,
  output logic [VA_W-1:0]     mem_addr_o,
  input  logic                mem_rsp_valid_i,
  input  logic [63:0]         mem_rsp_data_i
);
  localparam int VPN_W = VA_W - PG_W;

  logic [CID_W-1:0] lk_idx, cmd_idx, fill_idx;
  logic [VPN_W-1:0] lk_vpn, cmd_vpn, rd_tag, fill_tag;
  logic [PG_W-1:0]  cmd_code;
  logic             cmd_wr, cmd_pg, cmd_act;
  logic             rd_present, hit;
  logic [63:0]      rd_data;
  logic             walk_busy, walk_done, walk_fill, accept, start;

  iotlb_cidx #(.VA_W(VA_W), .CID_W(CID_W)) u_lk_idx (
    .mask_i(chain_mask_i), .addr_i(lk_iova_i), .idx_o(lk_idx)
  );
  iotlb_cidx #(.VA_W(VA_W), .CID_W(CID_W)) u_cmd_idx (
    .mask_i(chain_mask_i), .addr_i(cmd_word_i), .idx_o(cmd_idx)
  );

  assign lk_vpn   = lk_iova_i[VA_W-1:PG_W];
  assign cmd_vpn  = cmd_word_i[VA_W-1:PG_W];
  assign cmd_code = cmd_word_i[PG_W-1:0];
  assign cmd_wr   = cmd_valid_i && (cmd_code == PG_W'(OP_DWRITE));
  assign cmd_pg   = cmd_valid_i && (cmd_code == PG_W'(OP_PURGE));
  assign cmd_act  = cmd_wr | cmd_pg;

  iotlb_store #(.CID_W(CID_W), .VPN_W(VPN_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_idx_i    (lk_idx),
    .rd_present_o(rd_present),
    .rd_tag_o    (rd_tag),
    .rd_data_o   (rd_data),
    .cmd_we_i    (cmd_wr),
    .cmd_clr_i   (cmd_pg),
    .cmd_idx_i   (cmd_idx),
    .cmd_tag_i   (cmd_vpn),
    .cmd_data_i  ({stage_hi_i, stage_lo_i}),
    .fill_we_i   (walk_fill),
    .fill_idx_i  (fill_idx),
    .fill_tag_i  (fill_tag),
    .fill_data_i (mem_rsp_data_i)
  );

  assign hit        = rd_present && (rd_tag == lk_vpn) && rd_data[0];
  assign lk_ready_o = !walk_busy;
  assign accept     = lk_valid_i && lk_ready_o;
  assign start      = accept && (mode_i == TM_FETCH) && !hit && (mode_i != TM_REAL);

  iotlb_walk #(.VA_W(VA_W), .VPN_W(VPN_W), .CID_W(CID_W)) u_walk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .vpn_i      (lk_vpn),
    .idx_i      (lk_idx),
    .base_i     (pdir_base_i),
    .cmd_act_i  (cmd_act),
    .cmd_idx_i  (cmd_idx),
    .rsp_valid_i(mem_rsp_valid_i),
    .rsp_data_i (mem_rsp_data_i),
    .busy_o     (walk_busy),
    .req_o      (mem_req_o),
    .addr_o     (mem_addr_o),
    .done_o     (walk_done),
    .fill_o     (walk_fill),
    .fill_idx_o (fill_idx),
    .fill_tag_o (fill_tag)
  );

  xlat_t res_q;
  logic  res_valid_q, res_fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q <= 1'b0;
      res_fault_q <= 1'b0;
      res_q       <= '0;
    end else begin
      res_valid_q <= 1'b0;
      if (accept && !start) begin
        res_valid_q <= 1'b1;
        if (mode_i == TM_REAL) begin
          res_fault_q <= 1'b0;
          res_q       <= '{ppn: PPN_W'(lk_vpn), cidx: '0, hint: '0};
        end else if (hit) begin
          res_fault_q <= 1'b0;
          res_q       <= pde_decode(rd_data);
        end else begin
          res_fault_q <= 1'b1;
          res_q       <= '0;
        end
      end else if (walk_done) begin
        res_valid_q <= 1'b1;
        res_fault_q <= !mem_rsp_data_i[0];
        res_q       <= mem_rsp_data_i[0] ? pde_decode(mem_rsp_data_i) : '0;
      end
    end
  end

  assign res_valid_o = res_valid_q;
  assign res_fault_o = res_fault_q;
  assign res_ppn_o   = res_q.ppn;
  assign res_cidx_o  = res_q.cidx;
  assign res_hint_o  = res_q.hint;
endmodule

// File: rtl/iotlb_chain_chk.sv
module iotlb_chain_chk #(
  parameter int VA_W = 32,
  parameter int PG_W = 12
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      mode_i,
  input logic            lk_valid_i,
  input logic [VA_W-1:0] lk_iova_i,
  input logic            lk_ready_o,
  input logic            res_valid_o,
  input logic            res_fault_o,
  input logic [39:0]     res_ppn_o,
  input logic [11:0]     res_cidx_o,
  input logic [3:0]      res_hint_o,
  input logic            mem_req_o,
  input logic            mem_rsp_valid_i
);
  logic pend_q;
  logic acc;

  assign acc = lk_valid_i && lk_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pend_q <= 1'b0;
    else if (mem_req_o)       pend_q <= 1'b1;
    else if (mem_rsp_valid_i) pend_q <= 1'b0;
  end

  // R8
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  // R8
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || pend_q) |-> !lk_ready_o);

  // R9
  rsp_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && mem_rsp_valid_i) |=> res_valid_o);

  // R3
  real_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && mode_i == 2'd0) |=> (res_valid_o && !res_fault_o &&
      res_ppn_o == 40'($past(lk_iova_i[VA_W-1:PG_W])) &&
      res_cidx_o == '0 && res_hint_o == '0));

  // R7
  fault_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_fault_o) |->
      (res_ppn_o == '0 && res_cidx_o == '0 && res_hint_o == '0));

  // R7
  no_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && mode_i != 2'd2) |=> (res_valid_o && !mem_req_o));

  // R8
  one_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (res_valid_o ^ mem_req_o));

  // R12
  idle_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && !mem_req_o && mem_rsp_valid_i && !acc) |=> !res_valid_o);
endmodule

bind iotlb_chain iotlb_chain_chk #(.VA_W(VA_W), .PG_W(PG_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .mode_i         (mode_i),
  .lk_valid_i     (lk_valid_i),
  .lk_iova_i      (lk_iova_i),
  .lk_ready_o     (lk_ready_o),
  .res_valid_o    (res_valid_o),
  .res_fault_o    (res_fault_o),
  .res_ppn_o      (res_ppn_o),
  .res_cidx_o     (res_cidx_o),
  .res_hint_o     (res_hint_o),
  .mem_req_o      (mem_req_o),
  .mem_rsp_valid_i(mem_rsp_valid_i)
);

// File: tb/sim_iotlb_chain.sv
module sim_iotlb_chain;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [31:0] chain_mask_i = 32'hFF00_0000;
  logic [31:0] pdir_base_i = 32'h4000_0000;
  logic        cmd_valid_i = 1'b0;
  logic [31:0] cmd_word_i = '0;
  logic [31:0] stage_hi_i = '0;
  logic [31:0] stage_lo_i = '0;
  logic        lk_valid_i = 1'b0;
  logic [31:0] lk_iova_i = '0;
  logic        lk_ready_o, res_valid_o, res_fault_o, mem_req_o;
  logic [39:0] res_ppn_o;
  logic [11:0] res_cidx_o;
  logic [3:0]  res_hint_o;
  logic [31:0] mem_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [63:0] mem_rsp_data_i = '0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  iotlb_chain u0 (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int sh     = 24;

  bit         m_pres [256];
  logic [19:0] m_tag [256];
  logic [63:0] m_data[256];

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bidx(input logic [19:0] v);
    logic [31:0] a;
    a = {v, 12'h000} >> sh;
    return a[7:0];
  endfunction

  function automatic logic [63:0] gen(input logic [19:0] v);
    logic [31:0] w0, w1;
    w0 = {v[3:0] ^ 4'h9, v[11:0] ^ 12'h5a5, v[19:4] ^ 16'h1234};
    w1 = {v ^ 20'h0f0f0, 5'b0, v[0], v[1], 2'b0, v[2], v[3], v[1:0] != 2'b11};
    return {w0, w1};
  endfunction

  // {fault, ppn, cidx, hint}
  function automatic logic [63:0] xl(input logic [63:0] e);
    logic [31:0] w0, w1;
    w0 = e[63:32];
    w1 = e[31:0];
    return {7'b0, 1'b0, w0[31:28], w0[15:0], w1[31:12], w0[27:16],
            w1[6], w1[5], w1[2], w1[1]};
  endfunction

  localparam logic [63:0] FAULT_X = {7'b0, 1'b1, 56'b0};

  function automatic logic [63:0] outs();
    return {7'b0, res_fault_o, res_ppn_o, res_cidx_o, res_hint_o};
  endfunction

  function automatic bit mhit(input logic [19:0] v);
    logic [7:0] i;
    i = bidx(v);
    return m_pres[i] && m_tag[i] == v && m_data[i][0];
  endfunction

  task automatic model_cmd(input logic [11:0] code, input logic [19:0] v,
                           input logic [63:0] e);
    logic [7:0] i;
    i = bidx(v);
    if (code == 12'd35) begin
      m_pres[i] = 1; m_tag[i] = v; m_data[i] = e;
    end else if (code == 12'd33) begin
      m_pres[i] = 0;
    end
  endtask

  task automatic cmd(input logic [11:0] code, input logic [19:0] v,
                     input logic [63:0] e);
    cmd_valid_i = 1; cmd_word_i = {v, code};
    stage_hi_i = e[63:32]; stage_lo_i = e[31:0];
    @(negedge clk_i);
    cmd_valid_i = 0;
    model_cmd(code, v, e);
  endtask

  task automatic look(input logic [19:0] v, input int lat, input bit cancel,
                      input string req);
    logic [63:0] exp;
    logic [63:0] pde;
    bit miss;
    miss = 0;
    if (mode_i == 2'd0) exp = {7'b0, 1'b0, 20'b0, v, 16'b0};
    else if (mhit(v)) exp = xl(m_data[bidx(v)]);
    else if (mode_i == 2'd2) miss = 1;
    else exp = FAULT_X;
    lk_valid_i = 1; lk_iova_i = {v, 12'($urandom)};
    @(negedge clk_i);
    lk_valid_i = 0;
    if (!miss) begin
      chk(res_valid_o && !mem_req_o, req, {res_valid_o, mem_req_o}, 2'b10);
      chk(outs() == exp, req, outs(), exp);
      return;
    end
    chk(mem_req_o && !res_valid_o && !lk_ready_o, {req, " R8 request"},
        {res_valid_o, mem_req_o, lk_ready_o}, 3'b010);
    chk(mem_addr_o == pdir_base_i + {9'b0, v, 3'b0}, {req, " R8 address"},
        mem_addr_o, pdir_base_i + {9'b0, v, 3'b0});
    for (int k = 0; k < lat; k++) begin
      if (k == 0 && cancel) cmd(12'd33, v, 64'b0);
      else @(negedge clk_i);
      chk(!lk_ready_o && !res_valid_o && !mem_req_o, {req, " R8 stall"},
          {lk_ready_o, res_valid_o, mem_req_o}, 3'b000);
    end
    pde = gen(v);
    mem_rsp_valid_i = 1; mem_rsp_data_i = pde;
    @(negedge clk_i);
    mem_rsp_valid_i = 0;
    exp = pde[0] ? xl(pde) : FAULT_X;
    chk(res_valid_o && lk_ready_o, {req, " R9 done"}, {res_valid_o, lk_ready_o}, 2'b11);
    chk(outs() == exp, {req, " R9 data"}, outs(), exp);
    if (pde[0] && !cancel) begin
      m_pres[bidx(v)] = 1; m_tag[bidx(v)] = v; m_data[bidx(v)] = pde;
    end
  endtask

  function automatic logic [19:0] pick();
    return {8'($urandom % 4), 4'($urandom % 2), 8'($urandom % 4)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] e;
    logic [63:0] exp;
    logic [19:0] va, vb;
    void'($urandom(32'd7177));
    for (int i = 0; i < 256; i++) m_pres[i] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1
    chk(!res_valid_o && lk_ready_o && !mem_req_o, "R1 reset outputs",
        {res_valid_o, lk_ready_o, mem_req_o}, 3'b010);
    mode_i = 2'd1;
    look(20'h01003, 1, 0, "R1 empty table");
    // R3
    mode_i = 2'd0;
    look(20'hABCDE, 1, 0, "R3 direct");
    // R4 R5
    mode_i = 2'd1;
    va = 20'h02101; vb = 20'h02002;
    e = {32'hDEAD_BEEF, 32'h1234_5067};
    cmd(12'd35, va, e);
    look(va, 1, 0, "R4 R5 written hit");
    // R2 same slot, other tag
    look(vb, 1, 0, "R2 tag mismatch");
    // R4 unknown code ignored
    cmd(12'd34, va, 64'b0);
    look(va, 1, 0, "R4 unknown code");
    // R4 purge by index only
    cmd(12'd33, vb, 64'b0);
    look(va, 1, 0, "R4 purge");
    // R6 invalid entry
    cmd(12'd35, va, {32'h1111_1111, 32'hFFFF_FFFE});
    look(va, 1, 0, "R6 invalid no hit");
    // R7 mode 3
    mode_i = 2'd3;
    look(va, 1, 0, "R7 reserved mode");
    // R6 R8 R9 fetch despite invalid stored entry
    mode_i = 2'd2;
    look(va, 2, 0, "R6 R9 fetch");
    mode_i = 2'd1;
    look(va, 1, 0, "R9 filled");
    // R9 invalid fetch, no fill
    mode_i = 2'd2;
    look(20'h03003, 3, 0, "R9 invalid pde");
    mode_i = 2'd1;
    look(20'h03003, 1, 0, "R9 no fill");
    // R10 cancel
    mode_i = 2'd2;
    look(20'h01102, 2, 1, "R10 cancel");
    mode_i = 2'd1;
    look(20'h01102, 1, 0, "R10 not filled");
    // R11 lookup with purge in same cycle
    cmd(12'd35, va, e);
    exp = xl(e);
    lk_valid_i = 1; lk_iova_i = {va, 12'h0}; cmd_valid_i = 1; cmd_word_i = {va, 12'd33};
    @(negedge clk_i);
    lk_valid_i = 0; cmd_valid_i = 0;
    model_cmd(12'd33, va, 64'b0);
    chk(res_valid_o && outs() == exp, "R11 old contents", outs(), exp);
    look(va, 1, 0, "R11 purge applied");
    // R12 stray response
    mem_rsp_valid_i = 1; mem_rsp_data_i = gen(20'h00001);
    @(negedge clk_i);
    mem_rsp_valid_i = 0;
    chk(!res_valid_o, "R12 stray response", res_valid_o, 0);
    // R2 other field position
    chain_mask_i = 32'h000F_F000; sh = 12;
    cmd(12'd35, 20'h10005, gen(20'h10005));
    cmd(12'd35, 20'h20005, gen(20'h20004) | 64'h1);
    look(20'h10005, 1, 0, "R2 evicted");
    look(20'h20005, 1, 0, "R2 shifted index");
    chain_mask_i = 32'hFF00_0000; sh = 24;
    // random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      logic [19:0] v;
      r = $urandom % 10;
      v = pick();
      if (r < 5) begin
        mode_i = ($urandom % 4 == 0) ? 2'($urandom % 4) : 2'd2;
        look(v, 1 + $urandom % 4, 0, "R9 random lookup");
      end else if (r < 6) begin
        mode_i = 2'd2;
        if (mhit(v)) look(v, 1, 0, "R5 random hit");
        else look(v, 1 + $urandom % 3, 1, "R10 random cancel");
      end else if (r < 7) begin
        cmd(12'd33, v, 64'b0);
      end else if (r < 9) begin
        cmd(12'd35, v, gen(v ^ 20'h00010));
      end else begin
        cmd(12'($urandom % 64), v, gen(v));
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule